// File: doc/BRIEF.md
# Top-Level Interrupt Request Unit

This block produces the single highest-priority interrupt request of a small processor. The event behind the request comes from one of two places. One is an external non-maskable pin, synchronised and edge-detected on a selectable edge. The other is a one-clock end-of-count pulse from a watchdog timer. The event sets a pending flag. The flag becomes a request through one of two masks. The maskable path also needs the global interrupt enable. The override path is a set-only mask that ignores the global enable.

The CPU acknowledges the request and later issues a return strobe. Between the two, a handler-active flag is set. That flag withholds any further top-level request and drives a blocking output that stops every lower-priority interrupt and DMA grant. Software reaches the control bits through a write strobe, a bit selector and one data bit. Each control bit is also brought out on its own output. Vector fetch and context save are handled elsewhere.

Top module: `top_irq_unit`

## Requirements
- R1: After reset, srcPin=1, edgeRise=0, pendingFlag=0, tlEnable=0, overrideMask=0, handlerActive=0, blockLower=0 and irqReq=0.
- R2: With srcPin=0 (bit select 0 written with 0), a one-cycle wdgEnd pulse sets pendingFlag at the next clock edge, and nmiPin edges do not set it.
- R3: With srcPin=1, a change on nmiPin sets pendingFlag at the third rising clock edge after the change, but only if the change matches the edge selected by edgeRise (bit select 1; 1 = rising, 0 = falling). While srcPin=1, wdgEnd has no effect.
- R4: With overrideMask=0, irqReq is 1 exactly when pendingFlag, tlEnable (bit select 3) and globalIen are all 1 and handlerActive is 0.
- R5: Writing 1 to bit select 4 sets overrideMask, and writing 0 there has no effect. Only reset clears it. While it is set, irqReq equals pendingFlag with handlerActive 0, whatever globalIen and tlEnable are.
- R6: Bit select 2 writes pendingFlag directly, and ack clears it. A source event in the same cycle as a software clear or an ack leaves pendingFlag at 1.
- R7: ack sets handlerActive at the next edge, and iret clears it. blockLower equals handlerActive.
- R8: While handlerActive is 1, irqReq stays 0 even when pendingFlag is 1 and the masks allow a request.
- R9: ack and iret leave overrideMask, tlEnable, srcPin and edgeRise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nmiPin | input | 1 | External non-maskable pin (asynchronous) |
| wdgEnd | input | 1 | Watchdog end-of-count pulse, one clock wide |
| globalIen | input | 1 | CPU global interrupt enable |
| regWrEn | input | 1 | Control bit write strobe |
| regSel | input | 3 | Bit selector: 0 source, 1 edge, 2 pending, 3 enable, 4 override set |
| regWrData | input | 1 | Value written to the selected bit |
| ack | input | 1 | CPU acknowledge of the top-level request |
| iret | input | 1 | Return from the top-level handler |
| irqReq | output | 1 | Top-level interrupt request |
| blockLower | output | 1 | Blocks all lower-priority and DMA grants |
| handlerActive | output | 1 | Top-level handler in progress |
| srcPin | output | 1 | Source select (1 pin, 0 watchdog) |
| edgeRise | output | 1 | Pin edge select (1 rising, 0 falling) |
| pendingFlag | output | 1 | Pending flag |
| tlEnable | output | 1 | Maskable-path enable |
| overrideMask | output | 1 | Set-only override mask |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions. In one, a source event meets a software clear of the pending flag. In the other, it meets an acknowledge. The pin path cannot be used for these, because its three-edge delay makes the event cycle hard to line up. The stimulus therefore uses the watchdog source and drives wdgEnd in the same cycle as the write strobe, and then again in the same cycle as ack. The override mask is also tested against writes of 0, an acknowledge and a return. Only a final reset is expected to clear it.

// File: rtl/top_irq_pkg.sv
package top_irq_pkg;
  localparam int REG_SEL_W = 3;
  localparam logic [REG_SEL_W-1:0] SEL_SRC  = 3'd0;
  localparam logic [REG_SEL_W-1:0] SEL_EDGE = 3'd1;
  localparam logic [REG_SEL_W-1:0] SEL_PEND = 3'd2;
  localparam logic [REG_SEL_W-1:0] SEL_EN   = 3'd3;
  localparam logic [REG_SEL_W-1:0] SEL_OVR  = 3'd4;

  typedef struct packed {
    logic wrSrc;
    logic wrEdge;
    logic wrPend;
    logic wrEn;
    logic setOvr;
    logic data;
    logic ack;
    logic iret;
  } ctrlStrobes_t;
endpackage

// File: rtl/top_irq_ctrl.sv
module top_irq_ctrl
  import top_irq_pkg::*;
(
  input  logic                 regWrEn,
  input  logic [REG_SEL_W-1:0] regSel,
  input  logic                 regWrData,
  input  logic                 ack,
  input  logic                 iret,
  output ctrlStrobes_t         strobes
);
  always_comb begin
    strobes        = '0;
    strobes.data   = regWrData;
    strobes.ack    = ack;
    strobes.iret   = iret;
    if (regWrEn) begin
      unique case (regSel)
        SEL_SRC:  strobes.wrSrc  = 1'b1;
        SEL_EDGE: strobes.wrEdge = 1'b1;
        SEL_PEND: strobes.wrPend = 1'b1;
        SEL_EN:   strobes.wrEn   = 1'b1;
        SEL_OVR:  strobes.setOvr = regWrData;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/top_irq_datapath.sv
module top_irq_datapath
  import top_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         nmiPin,
  input  logic         wdgEnd,
  input  logic         globalIen,
  input  ctrlStrobes_t strobes,
  output logic         irqReq,
  output logic         handlerActive,
  output logic         srcPin,
  output logic         edgeRise,
  output logic         pendingFlag,
  output logic         tlEnable,
  output logic         overrideMask
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic pinPrev;
  logic pinNow;
  logic pinEdge;
  logic srcEvent;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= nmiPin;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], nmiPin};
    end
  endgenerate

  assign pinNow   = syncQ[LAST];
  assign pinEdge  = edgeRise ? (pinNow & ~pinPrev) : (~pinNow & pinPrev);
  assign srcEvent = srcPin ? pinEdge : wdgEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinPrev       <= 1'b0;
      srcPin        <= 1'b1;
      edgeRise      <= 1'b0;
      tlEnable      <= 1'b0;
      overrideMask  <= 1'b0;
      pendingFlag   <= 1'b0;
      handlerActive <= 1'b0;
    end else begin
      pinPrev <= pinNow;
      if (strobes.wrSrc)  srcPin   <= strobes.data;
      if (strobes.wrEdge) edgeRise <= strobes.data;
      if (strobes.wrEn)   tlEnable <= strobes.data;
      if (strobes.setOvr) overrideMask <= 1'b1;
      if (srcEvent)            pendingFlag <= 1'b1;
      else if (strobes.ack)    pendingFlag <= 1'b0;
      else if (strobes.wrPend) pendingFlag <= strobes.data;
      if (strobes.ack)       handlerActive <= 1'b1;
      else if (strobes.iret) handlerActive <= 1'b0;
    end
  end

  assign irqReq = pendingFlag & ~handlerActive &
                  ((tlEnable & globalIen) | overrideMask);
endmodule

// File: rtl/top_irq_unit.sv
module top_irq_unit
  import top_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 nmiPin,
  input  logic                 wdgEnd,
  input  logic                 globalIen,
  input  logic                 regWrEn,
  input  logic [REG_SEL_W-1:0] regSel,
  input  logic                 regWrData,
  input  logic                 ack,
  input  logic                 iret,
  output logic                 irqReq,
  output logic                 blockLower,
  output logic                 handlerActive,
  output logic                 srcPin,
  output logic                 edgeRise,
  output logic                 pendingFlag,
  output logic                 tlEnable,
  output logic                 overrideMask
);
  ctrlStrobes_t strobes;

  top_irq_ctrl u_ctrl (
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .ack(ack), .iret(iret), .strobes(strobes)
  );

  top_irq_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin), .wdgEnd(wdgEnd),
    .globalIen(globalIen), .strobes(strobes), .irqReq(irqReq),
    .handlerActive(handlerActive), .srcPin(srcPin), .edgeRise(edgeRise),
    .pendingFlag(pendingFlag), .tlEnable(tlEnable), .overrideMask(overrideMask)
  );

  assign blockLower = handlerActive;
endmodule

// File: rtl/top_irq_checker.sv
module top_irq_checker (
  input logic clk,
  input logic rstN,
  input logic wdgEnd,
  input logic globalIen,
  input logic ack,
  input logic iret,
  input logic irqReq,
  input logic blockLower,
  input logic handlerActive,
  input logic srcPin,
  input logic edgeRise,
  input logic pendingFlag,
  input logic tlEnable,
  input logic overrideMask
);
  p_wdg_sets_pending_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!srcPin && wdgEnd) |=> pendingFlag);

  p_req_masked_path_r4: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !overrideMask) |-> (pendingFlag && tlEnable && globalIen));

  p_override_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    overrideMask |=> overrideMask);

  p_ack_activates_r7: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> handlerActive);

  p_iret_releases_r7: assert property (@(posedge clk) disable iff (!rstN)
    (iret && !ack) |=> !handlerActive);

  p_block_follows_r7: assert property (@(posedge clk) disable iff (!rstN)
    blockLower == handlerActive);

  p_no_req_in_handler_r8: assert property (@(posedge clk) disable iff (!rstN)
    handlerActive |-> !irqReq);

  p_ack_keeps_cfg_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ack || iret) |=> ($stable(tlEnable) && $stable(edgeRise) && $stable(srcPin)));
endmodule

bind top_irq_unit top_irq_checker u_chk (
  .clk(clk), .rstN(rstN), .wdgEnd(wdgEnd), .globalIen(globalIen),
  .ack(ack), .iret(iret), .irqReq(irqReq), .blockLower(blockLower),
  .handlerActive(handlerActive), .srcPin(srcPin), .edgeRise(edgeRise),
  .pendingFlag(pendingFlag), .tlEnable(tlEnable), .overrideMask(overrideMask)
);

// File: tb/top_irq_unit_bench.sv
`timescale 1ns/1ps
module top_irq_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nmiPin = 1'b0, wdgEnd = 1'b0, globalIen = 1'b0;
  logic regWrEn = 1'b0, regWrData = 1'b0, ack = 1'b0, iret = 1'b0;
  logic [2:0] regSel = 3'd0;
  logic irqReq, blockLower, handlerActive, srcPin, edgeRise;
  logic pendingFlag, tlEnable, overrideMask;
  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  top_irq_unit u_top_irq_unit (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin), .wdgEnd(wdgEnd),
    .globalIen(globalIen), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .ack(ack), .iret(iret), .irqReq(irqReq),
    .blockLower(blockLower), .handlerActive(handlerActive), .srcPin(srcPin),
    .edgeRise(edgeRise), .pendingFlag(pendingFlag), .tlEnable(tlEnable),
    .overrideMask(overrideMask)
  );

  // {pending, enable, globalIen, expected irqReq}, override clear
  localparam logic [3:0] VEC [8] = '{
    4'b0000, 4'b0010, 4'b0100, 4'b0110,
    4'b1000, 4'b1010, 4'b1100, 4'b1111
  };

  task automatic chk(input string req, input logic act, input logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulseWdg();
    @(negedge clk); wdgEnd = 1'b1;
    @(negedge clk); wdgEnd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 srcPin", srcPin, 1'b1);
    chk("R1 edgeRise", edgeRise, 1'b0);
    chk("R1 pending", pendingFlag, 1'b0);
    chk("R1 tlEnable", tlEnable, 1'b0);
    chk("R1 override", overrideMask, 1'b0);
    chk("R1 active", handlerActive, 1'b0);
    chk("R1 irqReq", irqReq, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 maskable path table
    for (int i = 0; i < 8; i++) begin
      wr(3'd2, VEC[i][3]);
      wr(3'd3, VEC[i][2]);
      globalIen = VEC[i][1];
      @(negedge clk);
      chk("R4 irqReq table", irqReq, VEC[i][0]);
    end
    globalIen = 1'b0;
    wr(3'd3, 1'b0);
    wr(3'd2, 1'b0);
    chk("R6 sw clear", pendingFlag, 1'b0);

    // R3 falling edge default: rising ignored, falling seen on third edge
    @(negedge clk); nmiPin = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 rise ignored", pendingFlag, 1'b0);
    nmiPin = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 fall not yet", pendingFlag, 1'b0);
    @(negedge clk);
    chk("R3 fall seen", pendingFlag, 1'b1);
    wr(3'd2, 1'b0);
    wr(3'd1, 1'b1);
    @(negedge clk); nmiPin = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 rise seen", pendingFlag, 1'b1);
    wr(3'd2, 1'b0);
    pulseWdg();
    @(negedge clk);
    chk("R3 wdg ignored", pendingFlag, 1'b0);

    // R2 watchdog source
    wr(3'd0, 1'b0);
    pulseWdg();
    chk("R2 wdg sets", pendingFlag, 1'b1);
    wr(3'd2, 1'b0);
    @(negedge clk); nmiPin = 1'b0;
    repeat (4) @(negedge clk); nmiPin = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 pin ignored", pendingFlag, 1'b0);

    // R6 event beats software clear and ack
    @(negedge clk);
    wdgEnd = 1'b1; regWrEn = 1'b1; regSel = 3'd2; regWrData = 1'b0;
    @(negedge clk);
    wdgEnd = 1'b0; regWrEn = 1'b0;
    chk("R6 event beats clear", pendingFlag, 1'b1);
    wdgEnd = 1'b1; ack = 1'b1;
    @(negedge clk);
    wdgEnd = 1'b0; ack = 1'b0;
    chk("R6 event beats ack", pendingFlag, 1'b1);
    chk("R7 ack activates", handlerActive, 1'b1);
    chk("R7 blockLower", blockLower, 1'b1);
    wr(3'd3, 1'b1);
    globalIen = 1'b1;
    @(negedge clk);
    chk("R8 no req while active", irqReq, 1'b0);
    iret = 1'b1;
    @(negedge clk); iret = 1'b0;
    chk("R7 iret releases", handlerActive, 1'b0);
    chk("R7 block released", blockLower, 1'b0);
    chk("R4 req after iret", irqReq, 1'b1);
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk("R6 ack clears", pendingFlag, 1'b0);
    chk("R9 enable kept", tlEnable, 1'b1);
    iret = 1'b1;
    @(negedge clk); iret = 1'b0;
    globalIen = 1'b0;
    wr(3'd3, 1'b0);

    // R5 override mask
    wr(3'd4, 1'b0);
    chk("R5 write0 ignored", overrideMask, 1'b0);
    wr(3'd4, 1'b1);
    chk("R5 set", overrideMask, 1'b1);
    wr(3'd2, 1'b1);
    chk("R5 req without ien", irqReq, 1'b1);
    wr(3'd4, 1'b0);
    chk("R5 clear ignored", overrideMask, 1'b1);
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk("R9 override kept on ack", overrideMask, 1'b1);
    chk("R9 src kept", srcPin, 1'b0);
    iret = 1'b1;
    @(negedge clk); iret = 1'b0;
    chk("R9 override kept on iret", overrideMask, 1'b1);
    chk("R9 edge kept", edgeRise, 1'b1);
    rstN = 1'b0;
    @(negedge clk);
    chk("R5 reset clears", overrideMask, 1'b0);
    chk("R1 src after reset", srcPin, 1'b1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule